// File: doc/BRIEF.md
# Interrupt Priority and Software Request Register Bank

This block is the register-facing front of an interrupt controller. It keeps a 4-bit priority for every interrupt source and a pending flag for each of eight software-raised sources. It also turns these, together with the peripheral request lines, into a pending vector. A combinational search over that vector names the most urgent source. Software reaches the registers through a simple bus port with byte, halfword and word transfers. Sources 0 to 7 are raised by software. Peripheral line k becomes source 8+k. The number of peripheral lines is the parameter `NPERIPH`.

A byte at bus address `a` always travels on data lane `a[1:0]` (bits `8*a[1:0]+7` down to `8*a[1:0]`), whatever the size of the transfer. A transfer covers `addr` and the bytes that follow it, and it has to stay inside one aligned 32-bit word. The size code is 0 for a byte, 1 for a halfword and 2 or 3 for a word. Writes commit on the rising clock edge. Read data is combinational while `bus_sel` is high.

Top module: `irq_prio_bank`

## Requirements
- R1: After reset every priority is 0, every software flag is 0, `pend_vec` is 0 when no peripheral line is high, `top_valid` is 0 and `bus_err` is 0.
- R2: The priority of source n sits at byte address 0x40+n. A write stores bits [3:0] of that byte. A read returns the stored value in bits [3:0] and zeros in bits [7:4]. `prio_flat[4n+3:4n]` shows the stored value.
- R3: Halfword and word transfers that stay within one aligned word read or write every byte they cover, each byte on its own lane. Lanes they do not cover read as zero and are left unwritten.
- R4: A transfer whose first byte offset plus its length is more than 4 writes nothing and reads all zeros. It drives `bus_err` high for exactly the following cycle.
- R5: The control byte of software source s (0..7) sits at byte address 0x20+s. Writing bit 1 (set) as 1 raises its flag. The byte reads back with the flag in bit 0 and zeros in bits [7:1].
- R6: Writing bit 0 (clear) as 1 lowers the flag, unless bit 1 is 1 in the same byte, in which case the flag ends up 1. A write with both bits 0 leaves the flag unchanged.
- R7: `pend_vec[s]` equals the flag of software source s. `pend_vec[8+k]` follows `periph_req[k]` in the same cycle.
- R8: `top_valid` is 1 exactly when some source is pending with a priority above 0. In that case `top_id` is the qualifying source with the greatest priority, ties go to the lowest index, and `top_prio` is its priority.
- R9: Addresses outside the two register ranges read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Transfer valid this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_addr | input | AW | Byte address of first byte |
| bus_wdata | input | 32 | Write data, byte per address lane |
| bus_rdata | output | 32 | Read data, byte per address lane |
| bus_err | output | 1 | One-cycle pulse after a word-crossing transfer |
| periph_req | input | NPERIPH | Peripheral request levels |
| pend_vec | output | NPERIPH+8 | Pending source vector |
| prio_flat | output | 4*(NPERIPH+8) | Priority of each source, 4 bits each |
| top_valid | output | 1 | Some pending source has nonzero priority |
| top_id | output | $clog2(NPERIPH+8) | Winning source index |
| top_prio | output | 4 | Winning priority |

## Verification
The hardest case to reach is a single write that both sets and clears the same software flag. Close to it are partial-word transfers that start at an odd offset, where only some lanes may change. The stimulus table reaches them with lane-shifted write data and reads back whole words, so that any stray lane shows. For the priority search, priorities are first set to tie on purpose, then peripheral lines and software flags are switched one at a time. This makes the lowest-index tie-break, the exclusion of priority 0 and the highest index each decide the winner in turn.

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
  parameter int NPERIPH = 24,
  parameter int AW      = 9,
  localparam int N      = NPERIPH + 8,
  localparam int IDW    = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_size,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_err,
  input  logic [NPERIPH-1:0] periph_req,
  output logic [N-1:0]     pend_vec,
  output logic [4*N-1:0]   prio_flat,
  output logic             top_valid,
  output logic [IDW-1:0]   top_id,
  output logic [3:0]       top_prio
);
  localparam int SOFT_BASE = 'h20;
  localparam int PRIO_BASE = 'h40;

  logic [3:0]    prio [N];
  logic [7:0]    soft_flag;
  logic [2:0]    nbytes;
  logic [3:0]    span_end;
  logic          in_word;
  logic [3:0]    lane_on, lane_soft, lane_prio;
  logic [AW-1:0] lane_addr [4];
  logic [2:0]    soft_idx [4];
  logic [IDW-1:0] prio_idx [4];

  assign nbytes   = (bus_size == 2'd0) ? 3'd1 : (bus_size == 2'd1) ? 3'd2 : 3'd4;
  assign span_end = {2'b00, bus_addr[1:0]} + {1'b0, nbytes};
  assign in_word  = span_end <= 4'd4;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      lane_addr[i] = {bus_addr[AW-1:2], 2'(i)};
      lane_on[i]   = bus_sel && in_word && (3'(i) >= {1'b0, bus_addr[1:0]})
                     && (4'(i) < span_end);
      lane_soft[i] = lane_addr[i][AW-1:3] == (AW-3)'(SOFT_BASE >> 3);
      lane_prio[i] = (lane_addr[i] >= AW'(PRIO_BASE)) && (lane_addr[i] < AW'(PRIO_BASE + N));
      soft_idx[i]  = lane_addr[i][2:0];
      prio_idx[i]  = IDW'(lane_addr[i] - AW'(PRIO_BASE));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_flag <= '0;
      bus_err   <= 1'b0;
      for (int n = 0; n < N; n++) prio[n] <= 4'd0;
    end else begin
      bus_err <= bus_sel && !in_word;
      for (int i = 0; i < 4; i++) begin
        if (lane_on[i] && bus_we) begin
          if (lane_soft[i]) begin
            if (bus_wdata[8*i+1])      soft_flag[soft_idx[i]] <= 1'b1;
            else if (bus_wdata[8*i])   soft_flag[soft_idx[i]] <= 1'b0;
          end
          if (lane_prio[i]) prio[prio_idx[i]] <= bus_wdata[8*i +: 4];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < 4; i++) begin
      if (lane_on[i] && !bus_we) begin
        if (lane_soft[i]) bus_rdata[8*i +: 8] = {7'b0, soft_flag[soft_idx[i]]};
        if (lane_prio[i]) bus_rdata[8*i +: 8] = {4'b0, prio[prio_idx[i]]};
      end
    end
  end

  assign pend_vec = {periph_req, soft_flag};

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flat
      assign prio_flat[4*g +: 4] = prio[g];
    end
  endgenerate

  always_comb begin
    top_prio = 4'd0;
    top_id   = '0;
    for (int n = 0; n < N; n++) begin
      if (pend_vec[n] && (prio[n] > top_prio)) begin
        top_prio = prio[n];
        top_id   = IDW'(n);
      end
    end
  end

  assign top_valid = top_prio != 4'd0;
endmodule

module irq_prio_bank_chk #(
  parameter int NPERIPH = 24,
  parameter int AW      = 9,
  localparam int N      = NPERIPH + 8,
  localparam int IDW    = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [1:0]       bus_size,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             bus_err,
  input logic [NPERIPH-1:0] periph_req,
  input logic [N-1:0]     pend_vec,
  input logic [4*N-1:0]   prio_flat,
  input logic             top_valid,
  input logic [IDW-1:0]   top_id,
  input logic [3:0]       top_prio
);
  logic [3:0] len;
  logic       crosses, any_ok, soft0_byte;
  assign len        = (bus_size == 2'd0) ? 4'd1 : (bus_size == 2'd1) ? 4'd2 : 4'd4;
  assign crosses    = ({2'b00, bus_addr[1:0]} + len) > 4'd4;
  assign soft0_byte = bus_sel && bus_we && bus_size == 2'd0 && bus_addr == AW'('h20);

  always_comb begin
    any_ok = 1'b0;
    for (int n = 0; n < N; n++)
      if (pend_vec[n] && prio_flat[4*n +: 4] != 4'd0) any_ok = 1'b1;
  end

  a_r4_err_after_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && crosses) |=> bus_err);
  a_r4_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel && crosses));
  a_r5_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (soft0_byte && bus_wdata[1]) |=> pend_vec[0]);
  a_r6_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (soft0_byte && bus_wdata[0] && !bus_wdata[1]) |=> !pend_vec[0]);
  a_r2_prio_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_size == 2'd0 && bus_addr == AW'('h40))
      |=> prio_flat[3:0] == $past(bus_wdata[3:0]));
  a_r8_winner_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (pend_vec[top_id] && top_prio != 4'd0 && prio_flat[4*top_id +: 4] == top_prio));
  a_r8_none_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
    !top_valid |-> !any_ok);
  a_r7_periph_follow: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vec[N-1:8] == periph_req);
endmodule

bind irq_prio_bank irq_prio_bank_chk #(.NPERIPH(NPERIPH), .AW(AW)) u_chk (.*);

// File: tb/sim_irq_prio_bank.sv
`timescale 1ns/1ps
module sim_irq_prio_bank;
  localparam int NP = 24;
  localparam int AW = 9;
  localparam int N  = NP + 8;

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_we = 0;
  logic [1:0] bus_size = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_err;
  logic [NP-1:0] periph_req = 0;
  logic [N-1:0] pend_vec;
  logic [4*N-1:0] prio_flat;
  logic top_valid;
  logic [4:0] top_id;
  logic [3:0] top_prio;
  int checks = 0, failures = 0;
  logic [31:0] rd;
  logic er;

  always #2.5 clk = ~clk;

  irq_prio_bank #(.NPERIPH(NP), .AW(AW)) u0 (.*);

  // {we, err, size[1:0], addr[8:0], data[31:0]}; data is wdata for writes, expected rdata for reads
  localparam int NV = 22;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1,1'b0,2'd0,9'h040,32'h000000AB},  // R2 upper nibble dropped
    {1'b0,1'b0,2'd0,9'h040,32'h0000000B},  // R2
    {1'b1,1'b0,2'd1,9'h042,32'h0C0D0000},  // R3 halfword
    {1'b0,1'b0,2'd2,9'h040,32'h0C0D000B},  // R3 word read
    {1'b1,1'b0,2'd2,9'h044,32'h04030201},  // R3 word write
    {1'b0,1'b0,2'd1,9'h045,32'h00030200},  // R3 odd-offset halfword
    {1'b1,1'b1,2'd1,9'h043,32'hFFFFFFFF},  // R4 crossing write
    {1'b0,1'b0,2'd2,9'h040,32'h0C0D000B},  // R4 unchanged
    {1'b0,1'b0,2'd2,9'h044,32'h04030201},  // R4 unchanged
    {1'b0,1'b1,2'd2,9'h042,32'h00000000},  // R4 crossing read
    {1'b1,1'b0,2'd0,9'h021,32'h00000200},  // R5 set soft1
    {1'b0,1'b0,2'd2,9'h020,32'h00000100},  // R5 readback
    {1'b1,1'b0,2'd0,9'h021,32'h00000300},  // R6 set wins
    {1'b0,1'b0,2'd0,9'h021,32'h00000100},  // R6
    {1'b1,1'b0,2'd0,9'h021,32'h00000100},  // R6 clear
    {1'b0,1'b0,2'd0,9'h021,32'h00000000},  // R6
    {1'b1,1'b0,2'd2,9'h024,32'h02020202},  // R5 set 4..7
    {1'b1,1'b0,2'd2,9'h024,32'h00000000},  // R6 zeros no effect
    {1'b0,1'b0,2'd2,9'h024,32'h01010101},  // R6
    {1'b1,1'b0,2'd2,9'h010,32'hFFFFFFFF},  // R9 unmapped write
    {1'b0,1'b0,2'd2,9'h010,32'h00000000},  // R9 unmapped read
    {1'b1,1'b0,2'd2,9'h024,32'h01010101}   // R6 clear all
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [1:0] sz, input logic [AW-1:0] a,
                      input logic [31:0] wd, output logic [31:0] r, output logic e);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
    #1 r = bus_rdata;
    @(negedge clk);
    e = bus_err;
    bus_sel = 0; bus_we = 0; bus_wdata = 0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [AW-1:0] a, input logic [31:0] wd);
    logic [31:0] r; logic e;
    xfer(1'b1, sz, a, wd, r, e);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 pend", 32'(pend_vec), 32'h0);
    chk("R1 valid", {31'b0, top_valid}, 32'h0);
    chk("R1 err", {31'b0, bus_err}, 32'h0);
    xfer(1'b0, 2'd2, 9'h05C, 0, rd, er);
    chk("R1 prio", rd, 32'h0);
    xfer(1'b0, 2'd2, 9'h020, 0, rd, er);
    chk("R1 soft", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][44], VEC[i][42:41], VEC[i][40:32], VEC[i][31:0], rd, er);
      if (!VEC[i][44]) chk($sformatf("R2/R3/R4/R5/R6/R9 read %0d", i), rd, VEC[i][31:0]);
      chk($sformatf("R4 err flag %0d", i), {31'b0, er}, {31'b0, VEC[i][43]});
    end
    chk("R6 all cleared", 32'(pend_vec), 32'h0);
    chk("R2 prio_flat", prio_flat[31:0], 32'h4321CD0B);

    // R8 tie-break: sources 9 and 20 both priority 5
    wr(2'd0, 9'h049, 32'h00000500);
    wr(2'd0, 9'h054, 32'h00000005);
    periph_req = 24'h001002;
    settle();
    chk("R7 pend", 32'(pend_vec), 32'h00100200);
    chk("R8 tie id", 32'(top_id), 32'd9);
    chk("R8 tie prio", 32'(top_prio), 32'd5);
    chk("R8 valid", {31'b0, top_valid}, 32'h1);
    periph_req = 24'h001000;
    settle();
    chk("R8 single id", 32'(top_id), 32'd20);
    // R7 soft flag into pend; source 2 prio 13 wins
    wr(2'd0, 9'h022, 32'h00020000);
    settle();
    chk("R7 soft pend", 32'(pend_vec), 32'h00100004);
    chk("R8 soft wins", 32'(top_id), 32'd2);
    chk("R8 soft prio", 32'(top_prio), 32'd13);
    // R8 priority zero excluded
    wr(2'd0, 9'h022, 32'h00010000);
    periph_req = 24'h000001;
    settle();
    chk("R7 periph0", 32'(pend_vec), 32'h00000100);
    chk("R8 none valid", {31'b0, top_valid}, 32'h0);
    // R8 highest index, highest priority
    wr(2'd0, 9'h05F, 32'h0F000000);
    periph_req = 24'h800001;
    settle();
    chk("R8 top id 31", 32'(top_id), 32'd31);
    chk("R8 top prio 15", 32'(top_prio), 32'd15);
    chk("R2 prio_flat top", 32'(prio_flat[127:124]), 32'hF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule